// File: doc/BRIEF.md
# Event Counting Performance Monitor

This block counts hardware events for profiling. It has one free-running cycle counter and two general counters. Each general counter chooses one strobe from a bus of numbered event inputs through an 8-bit code held in a single control word. A global run bit starts and stops every counter together. No counter has an enable of its own, so software parks a general counter by pointing it at a strobe that stays idle, the trace-output strobe at code 0x20.

When a counter wraps it sets a sticky overflow flag. Software acknowledges flags by writing 1 to them. Writing the control word back unchanged is harmless, so an interrupt handler can read the word and write the same value back to clear exactly the flags it saw. The three flags, each gated by its own interrupt enable, drive one shared interrupt line. All registers sit behind a small word-addressed port: writes take effect on the clock edge, and reads are combinational.

Top module: `perf_mon`

## Requirements
- R1: After the asynchronous reset, every register reads 0 and `irq_o` is 0.
- R2: The control word is at address 0. Bit 0 is the global run bit and bit 3 is the cycle divider. Bits 6:4 are the interrupt enables for counter 0, counter 1 and the cycle counter. Bits 10:8 are their overflow flags. Bits 27:20 hold counter 0's event code and bits 19:12 hold counter 1's. Bits 31:28, 11, 7 and 2:1 read as 0.
- R3: The cycle counter is at address 1, counter 0 at address 2 and counter 1 at address 3. A write loads any 32-bit value, zero included, and takes priority over a count in the same cycle.
- R4: Writing 1 to control bit 1 clears both general counters. Writing 1 to control bit 2 clears the cycle counter and its prescaler. Neither bit is stored.
- R5: While the run bit is 0, no counter changes except by a register write or a reset bit.
- R6: While running, a general counter adds one on every clock in which `evt_i[code]` is high, where code is its 8-bit event code.
- R7: Code 0x20 selects `evt_i[32]`, the trace-output strobe. While that strobe is low, the counter holds its value whatever the other strobes do.
- R8: Code 0xFF makes a general counter add one on every running clock. Any other code at or above NUM_EVT never counts.
- R9: While running, the cycle counter adds one on every clock. With the divider bit set, it adds one once every 64 clocks, first 64 clocks after a cycle-counter reset.
- R10: A count from 0xFFFFFFFF wraps to 0 and sets that counter's flag in the same cycle. The flag then stays set.
- R11: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R12: `irq_o` is 1 exactly when some flag is set and its interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 cycle, 2 counter 0, 3 counter 1 |
| reg_wdata_i | input | 32 | Write data |
| evt_i | input | NUM_EVT | Event strobes; bit n is event code n |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
Five properties are checked on every cycle:
- A flag never drops unless a write-one clears it.
- A wrap to zero that no write caused always carries its flag.
- Nothing moves while the run bit is low and no write arrives.
- The undivided cycle counter steps by exactly one.
- The interrupt stays low while no flag is set.

Only the bench scenarios can show the rest:
- the field layout and readback of the control word,
- selecting a strobe by its code,
- parking on the trace strobe,
- codes that have no source,
- the exact 64-clock spacing of the divider,
- the interrupt following the enable bits in both directions.

// File: rtl/perf_mon_pkg.sv
`timescale 1ns/1ps
package perf_mon_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned SEL_W = 8;
  localparam int unsigned NUM_CNT = 3;  // index 0,1 general, 2 cycle
  // control word bit positions
  localparam int unsigned B_RUN = 0;
  localparam int unsigned B_CLR_GEN = 1;
  localparam int unsigned B_CLR_CYC = 2;
  localparam int unsigned B_DIV = 3;
  localparam int unsigned B_IEN = 4;
  localparam int unsigned B_FLAG = 8;
  localparam int unsigned B_SEL1 = 12;
  localparam int unsigned B_SEL0 = 20;
  localparam logic [SEL_W-1:0] CODE_EVERY_CLK = 8'hFF;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CYC  = 2'd1,
    A_GEN0 = 2'd2,
    A_GEN1 = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pm_ctrl_reg.sv
`timescale 1ns/1ps
module pm_ctrl_reg
  import perf_mon_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_W-1:0]      wdata_i,
  input  logic [NUM_CNT-1:0]    ovf_i,
  output logic                  run_o,
  output logic                  div_o,
  output logic [NUM_CNT-1:0]    ien_o,
  output logic [NUM_CNT-1:0]    flag_o,
  output logic [1:0][SEL_W-1:0] sel_o,
  output logic                  clr_gen_o,
  output logic                  clr_cyc_o,
  output logic [REG_W-1:0]      rdata_o
);
  logic                  run_q, div_q;
  logic [NUM_CNT-1:0]    ien_q, flag_q, w1c;
  logic [1:0][SEL_W-1:0] sel_q;
  logic                  unused_wbits;

  assign unused_wbits = ^{wdata_i[31:28], wdata_i[11], wdata_i[7]};
  assign w1c       = we_i ? wdata_i[B_FLAG +: NUM_CNT] : '0;
  assign clr_gen_o = we_i & wdata_i[B_CLR_GEN];
  assign clr_cyc_o = we_i & wdata_i[B_CLR_CYC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      div_q  <= 1'b0;
      ien_q  <= '0;
      flag_q <= '0;
      sel_q  <= '0;
    end else begin
      // a new overflow wins over a same-cycle clear
      flag_q <= (flag_q & ~w1c) | ovf_i;
      if (we_i) begin
        run_q    <= wdata_i[B_RUN];
        div_q    <= wdata_i[B_DIV];
        ien_q    <= wdata_i[B_IEN +: NUM_CNT];
        sel_q[0] <= wdata_i[B_SEL0 +: SEL_W];
        sel_q[1] <= wdata_i[B_SEL1 +: SEL_W];
      end
    end
  end

  assign run_o  = run_q;
  assign div_o  = div_q;
  assign ien_o  = ien_q;
  assign flag_o = flag_q;
  assign sel_o  = sel_q;
  assign rdata_o = {4'b0, sel_q[0], sel_q[1], 1'b0, flag_q, 1'b0, ien_q,
                    div_q, 2'b00, run_q};
endmodule

// File: rtl/pm_evt_counter.sv
`timescale 1ns/1ps
module pm_evt_counter
  import perf_mon_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_EVT = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit, inc;

  always_comb begin
    hit = (sel_i == CODE_EVERY_CLK);
    for (int i = 0; i < NUM_EVT; i++) begin
      if (sel_i == SEL_W'(i)) hit = hit | evt_i[i];
    end
  end

  assign inc   = run_i & hit & ~clr_i & ~wr_i;
  assign ovf_o = inc & (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pm_cyc_counter.sv
`timescale 1ns/1ps
module pm_cyc_counter #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned DIV_LOG2 = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             div_i,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0]    cnt_q;
  logic [DIV_LOG2-1:0] pre_q;
  logic                tick, inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (run_i)  pre_q <= pre_q + 1'b1;
  end

  assign tick  = run_i & (~div_i | (pre_q == '1));
  assign inc   = tick & ~clr_i & ~wr_i;
  assign ovf_o = inc & (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/perf_mon.sv
`timescale 1ns/1ps
module perf_mon
  import perf_mon_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NUM_EVT  = 64,
  parameter int unsigned DIV_LOG2 = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_o
);
  logic                  glb_en, cyc_div, clr_gen, clr_cyc;
  logic [NUM_CNT-1:0]    irq_en, ovf_flag, ovf_pulse;
  logic [1:0][SEL_W-1:0] evt_sel;
  logic [1:0][CNT_W-1:0] evt_cnt;
  logic [CNT_W-1:0]      cyc_cnt;
  logic [REG_W-1:0]      ctrl_rdata;

  pm_ctrl_reg i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i && reg_addr_i == A_CTRL),
    .wdata_i   (reg_wdata_i),
    .ovf_i     (ovf_pulse),
    .run_o     (glb_en),
    .div_o     (cyc_div),
    .ien_o     (irq_en),
    .flag_o    (ovf_flag),
    .sel_o     (evt_sel),
    .clr_gen_o (clr_gen),
    .clr_cyc_o (clr_cyc),
    .rdata_o   (ctrl_rdata)
  );

  for (genvar g = 0; g < 2; g++) begin : g_gen
    pm_evt_counter #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) i_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (glb_en),
      .sel_i   (evt_sel[g]),
      .evt_i   (evt_i),
      .clr_i   (clr_gen),
      .wr_i    (reg_we_i && reg_addr_i == 2'(A_GEN0 + g)),
      .wdata_i (reg_wdata_i[CNT_W-1:0]),
      .cnt_o   (evt_cnt[g]),
      .ovf_o   (ovf_pulse[g])
    );
  end

  pm_cyc_counter #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) i_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (glb_en),
    .div_i   (cyc_div),
    .clr_i   (clr_cyc),
    .wr_i    (reg_we_i && reg_addr_i == A_CYC),
    .wdata_i (reg_wdata_i[CNT_W-1:0]),
    .cnt_o   (cyc_cnt),
    .ovf_o   (ovf_pulse[2])
  );

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_rdata;
      A_CYC:   reg_rdata_o = REG_W'(cyc_cnt);
      A_GEN0:  reg_rdata_o = REG_W'(evt_cnt[0]);
      default: reg_rdata_o = REG_W'(evt_cnt[1]);
    endcase
  end

  assign irq_o = |(ovf_flag & irq_en);
endmodule

// File: rtl/perf_mon_chk.sv
`timescale 1ns/1ps
module perf_mon_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_we_i,
  input logic [1:0]            reg_addr_i,
  input logic [2:0]            flag_wdata_i,
  input logic                  glb_en_i,
  input logic                  cyc_div_i,
  input logic [2:0]            ovf_flag_i,
  input logic [CNT_W-1:0]      cyc_cnt_i,
  input logic [1:0][CNT_W-1:0] evt_cnt_i,
  input logic                  irq_i
);
  for (genvar k = 0; k < 3; k++) begin : g_flag
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_flag_i[k] && !(reg_we_i && reg_addr_i == 2'd0 && flag_wdata_i[k]))
      |=> ovf_flag_i[k]); // R11
  end

  for (genvar k = 0; k < 2; k++) begin : g_wrap
    AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_cnt_i[k] == '0 && $past(evt_cnt_i[k]) == '1 && !$past(reg_we_i))
      |-> ovf_flag_i[k]); // R10
  end

  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en_i && !reg_we_i) |=> ($stable(cyc_cnt_i) && $stable(evt_cnt_i))); // R5

  AST_CYC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en_i && !cyc_div_i && !reg_we_i)
    |=> cyc_cnt_i == $past(cyc_cnt_i) + 1'b1); // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_i == 3'b000) |-> !irq_i); // R12
endmodule

bind perf_mon perf_mon_chk #(.CNT_W(CNT_W)) i_perf_mon_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .flag_wdata_i (reg_wdata_i[10:8]),
  .glb_en_i     (glb_en),
  .cyc_div_i    (cyc_div),
  .ovf_flag_i   (ovf_flag),
  .cyc_cnt_i    (cyc_cnt),
  .evt_cnt_i    (evt_cnt),
  .irq_i        (irq_o)
);

// File: tb/test_perf_mon.sv
`timescale 1ns/1ps
module test_perf_mon;
  localparam logic [1:0] K_WR = 2'd0, K_CHK = 2'd1, K_IDLE = 2'd2;
  localparam int N_VEC = 31;

  typedef struct packed {
    bit [1:0]  kind;
    bit [1:0]  addr;
    bit [31:0] val;
    bit [15:0] tag;
  } vec_t;

  localparam vec_t TBL [N_VEC] = '{
    '{K_CHK, 2'd0, 32'h0, "R1"},
    '{K_CHK, 2'd1, 32'h0, "R1"},
    '{K_CHK, 2'd2, 32'h0, "R1"},
    '{K_CHK, 2'd3, 32'h0, "R1"},
    '{K_WR,  2'd2, 32'h12345678, "R3"},
    '{K_CHK, 2'd2, 32'h12345678, "R3"},
    '{K_WR,  2'd3, 32'hCAFEF00D, "R3"},
    '{K_CHK, 2'd3, 32'hCAFEF00D, "R3"},
    '{K_WR,  2'd0, 32'h00000002, "R4"},
    '{K_CHK, 2'd2, 32'h0, "R4"},
    '{K_CHK, 2'd3, 32'h0, "R4"},
    '{K_CHK, 2'd0, 32'h0, "R4"},
    '{K_WR,  2'd0, 32'hFFFFF8FE, "R2"},
    '{K_CHK, 2'd0, 32'h0FFFF078, "R2"},
    '{K_WR,  2'd0, 32'h00705010, "R2"},
    '{K_CHK, 2'd0, 32'h00705010, "R2"},
    '{K_IDLE, 2'd0, 32'd4, "R5"},
    '{K_CHK, 2'd1, 32'h0, "R5"},
    '{K_WR,  2'd0, 32'h00705011, "R9"},
    '{K_CHK, 2'd1, 32'h0, "R9"},
    '{K_IDLE, 2'd0, 32'd5, "R9"},
    '{K_CHK, 2'd1, 32'd5, "R9"},
    '{K_WR,  2'd0, 32'h00705010, "R5"},
    '{K_CHK, 2'd1, 32'd6, "R5"},
    '{K_IDLE, 2'd0, 32'd3, "R5"},
    '{K_CHK, 2'd1, 32'd6, "R5"},
    '{K_WR,  2'd0, 32'h00705014, "R4"},
    '{K_CHK, 2'd1, 32'h0, "R4"},
    '{K_CHK, 2'd0, 32'h00705010, "R4"},
    '{K_WR,  2'd1, 32'hABCD0000, "R3"},
    '{K_CHK, 2'd1, 32'hABCD0000, "R3"}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [63:0] evt_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;
  int          n_chk = 0, n_bad = 0;
  int          e0, e1;

  always #10 clk = ~clk;

  perf_mon i_perf_mon (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .evt_i(evt_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr_i = a;
    #1;
    n_chk++;
    if (reg_rdata_o !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata_o, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #1;
    n_chk++;
    if (irq_o !== exp) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, exp);
    end
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL R1..: watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk_irq(1'b0, "R1");
    for (int v = 0; v < N_VEC; v++) begin
      case (TBL[v].kind)
        K_WR:    wr(TBL[v].addr, TBL[v].val);
        K_IDLE:  idle(int'(TBL[v].val));
        default: chk(TBL[v].addr, TBL[v].val, string'(TBL[v].tag));
      endcase
    end

    // R6: strobe selection, codes 7 and 5
    wr(2'd0, 32'h00705013);
    e0 = 0; e1 = 0;
    for (int i = 0; i < 20; i++) begin
      evt_i = '0;
      evt_i[7] = (i % 3 == 0);
      evt_i[5] = (i % 2 == 0);
      evt_i[6] = 1'b1;
      if (i % 3 == 0) e0++;
      if (i % 2 == 0) e1++;
      @(negedge clk);
    end
    evt_i = '0;
    chk(2'd2, e0, "R6");
    chk(2'd3, e1, "R6");

    // R5: stopped counters ignore strobes
    wr(2'd0, 32'h00705010);
    evt_i = '1;
    idle(3);
    evt_i = '0;
    chk(2'd2, e0, "R5");

    // R7: parked on the trace strobe
    wr(2'd0, 32'h02005011);
    evt_i = '1; evt_i[32] = 1'b0;
    idle(4);
    e1 += 4;
    chk(2'd2, e0, "R7");
    evt_i = '0; evt_i[32] = 1'b1;
    idle(3);
    e0 += 3;
    evt_i = '0;
    chk(2'd2, e0, "R7");
    chk(2'd3, e1, "R7");

    // R8: code with no source, then every-clock code
    wr(2'd0, 32'h02080011);
    evt_i = '1;
    idle(5);
    e0 += 5;
    evt_i = '0;
    chk(2'd3, e1, "R8");
    chk(2'd2, e0, "R8");
    wr(2'd0, 32'h020FF011);
    wr(2'd3, 32'h0);
    idle(4);
    chk(2'd3, 32'd4, "R8");

    // R10 R11 R12: counter 0 wrap, flag and interrupt
    wr(2'd0, 32'h00700011);
    wr(2'd2, 32'hFFFFFFFE);
    evt_i[7] = 1'b1; @(negedge clk); evt_i = '0;
    chk(2'd2, 32'hFFFFFFFF, "R10");
    chk(2'd0, 32'h00700011, "R10");
    chk_irq(1'b0, "R12");
    evt_i[7] = 1'b1; @(negedge clk); evt_i = '0;
    chk(2'd2, 32'h0, "R10");
    chk(2'd0, 32'h00700111, "R10");
    chk_irq(1'b1, "R12");
    idle(3);
    chk(2'd0, 32'h00700111, "R10");
    wr(2'd0, 32'h00700001);
    chk(2'd0, 32'h00700101, "R11");
    chk_irq(1'b0, "R12");
    wr(2'd0, 32'h00700011);
    chk_irq(1'b1, "R12");
    wr(2'd0, 32'h00700111);
    chk(2'd0, 32'h00700011, "R11");
    chk_irq(1'b0, "R11");

    // R10: cycle counter wrap
    wr(2'd0, 32'h00700051);
    wr(2'd1, 32'hFFFFFFFD);
    idle(2);
    chk(2'd1, 32'hFFFFFFFF, "R10");
    chk(2'd0, 32'h00700051, "R10");
    idle(1);
    chk(2'd1, 32'h0, "R10");
    chk(2'd0, 32'h00700451, "R10");
    chk_irq(1'b1, "R12");
    wr(2'd0, 32'h00700451);
    chk(2'd0, 32'h00700051, "R11");
    chk_irq(1'b0, "R11");

    // R10: counter 1 wrap on every-clock code
    wr(2'd0, 32'h000FF021);
    wr(2'd3, 32'hFFFFFFFF);
    idle(1);
    chk(2'd3, 32'h0, "R10");
    chk(2'd0, 32'h000FF221, "R10");
    chk_irq(1'b1, "R12");
    wr(2'd0, 32'h000FF221);
    chk(2'd0, 32'h000FF021, "R11");

    // R9: divided cycle count
    wr(2'd0, 32'h0000000D);
    chk(2'd0, 32'h00000009, "R9");
    chk(2'd1, 32'h0, "R9");
    idle(63);
    chk(2'd1, 32'h0, "R9");
    idle(1);
    chk(2'd1, 32'd1, "R9");
    idle(64);
    chk(2'd1, 32'd2, "R9");

    // R1: asynchronous reset mid-run
    rst_ni = 1'b0;
    chk(2'd0, 32'h0, "R1");
    chk(2'd1, 32'h0, "R1");
    chk(2'd2, 32'h0, "R1");
    chk(2'd3, 32'h0, "R1");
    chk_irq(1'b0, "R1");
    @(negedge clk);
    rst_ni = 1'b1;
    idle(2);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule